// File: doc/BRIEF.md
# Quarter-Chip Early/Late Code Phase Tracker

This block keeps a spread-spectrum receiver sampling each chip at its best instant. Upstream logic delivers, once per chip, a vector of four complex samples taken a quarter chip apart. The block forwards one of them, the on-time sample, to the despreading fingers. It also watches the two samples on either side of that one.

Each side sample is multiplied by the conjugate of the complex scrambling code and summed over one symbol of chips. The block then compares the energies of the two sums. If one side clearly wins, the selected sample moves one quarter chip towards it. The block also drives the address of the scrambling-code ROM, and it adjusts that address when the selection crosses a chip boundary, so that the code stays aligned with the data.

The typical use is between the chip-rate down-sampler and the despreading fingers. A software-set threshold controls how much energy imbalance counts as a clear winner.

Top module: `qct_tracker`

## Requirements
- R1: While `rst_n` is low, `phase_idx` is 0, `flag` is 00, `flag_vld` and `rake_vld` are 0, and `code_addr` is 0.
- R2: One cycle after each cycle with `smp_vld` high, `rake_vld` is high and `rake_i`/`rake_q` carry phase `phase_idx` of that chip's sample vector. Phase k sits at bits [k*SMP_W +: SMP_W]. `rake_vld` is low after a cycle without `smp_vld`.
- R3: The early tap is phase (`phase_idx`-1) mod 4 and the late tap is phase (`phase_idx`+1) mod 4. Each tap is descrambled as re = i*c + q*d and im = q*c - i*d. Here c is -1 when `code_re_n` is 1 and +1 otherwise, and d is set by `code_im_n` in the same way.
- R4: Descrambled taps are summed over SF valid chips. Cycles without `smp_vld` do not count. `flag_vld` pulses for one cycle after the SF-th valid chip, and the sums then restart from zero.
- R5: At a decision, Pe and Pl are the I²+Q² energies of the early and late sums. `flag` becomes 01 (early) when Pe > Pl + `thr` and 10 (late) when Pl > Pe + `thr`; otherwise it becomes 00 (on-time). The flag holds until the next decision.
- R6: `phase_idx` changes only in the cycle where `flag_vld` is high. On an early flag it steps down by one (mod 4), on a late flag it steps up by one (mod 4), and on an on-time flag it stays the same.
- R7: `code_addr` advances by one per valid chip, modulo CODE_LEN. On the decision chip it advances by 2 if `phase_idx` wraps from 3 to 0, and by 0 if it wraps from 0 to 3.
- R8: If the energy difference equals `thr` exactly, the flag is on-time and `phase_idx` does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | A chip's sample vector is present |
| smp_i | input | 4*SMP_W | In-phase parts of the four phases, signed |
| smp_q | input | 4*SMP_W | Quadrature parts of the four phases, signed |
| code_re_n | input | 1 | Real part of the code at `code_addr` (1 means -1) |
| code_im_n | input | 1 | Imaginary part of the code at `code_addr` (1 means -1) |
| thr | input | THR_W | Energy difference threshold |
| code_addr | output | ADDR_W | Chip index into the scrambling-code ROM |
| phase_idx | output | 2 | Selected on-time phase |
| flag | output | 2 | Last decision: 00 on-time, 01 early, 10 late |
| flag_vld | output | 1 | Decision strobe |
| rake_vld | output | 1 | On-time sample valid |
| rake_i | output | SMP_W | On-time sample, in-phase |
| rake_q | output | SMP_W | On-time sample, quadrature |

## Verification
The bench drives a peak that steps from phase to phase, so the selection must wrap in both directions. A design that mishandled the ROM address there would lose code alignment, and every decision after that would differ from the model. A threshold set to exactly the energy difference, and then one below it, catches a comparison that uses the wrong operator (>= instead of >). Random gaps in `smp_vld` expose a chip counter that also counts idle cycles, because its decision would land early. A design whose tap selection or descrambling conjugate is swapped would move the index the wrong way.

// File: rtl/qct_pkg.sv
package qct_pkg;
    typedef enum logic [1:0] {
        TRK_ON    = 2'b00,
        TRK_EARLY = 2'b01,
        TRK_LATE  = 2'b10
    } trk_flag_e;
endpackage

// File: rtl/qct_despread.sv
// Multiply one complex sample by the conjugate of a +/-1 +/-j code chip.
module qct_despread #(
    parameter int SMP_W = 8,
    parameter int DSP_W = SMP_W + 2
) (
    input  logic signed [SMP_W-1:0] s_i,
    input  logic signed [SMP_W-1:0] s_q,
    input  logic                    c_re_n,
    input  logic                    c_im_n,
    output logic signed [DSP_W-1:0] d_re,
    output logic signed [DSP_W-1:0] d_im
);
    logic signed [DSP_W-1:0] xi, xq, ic, id, qc, qd;

    always_comb begin
        xi   = DSP_W'(s_i);
        xq   = DSP_W'(s_q);
        ic   = c_re_n ? -xi : xi;
        qc   = c_re_n ? -xq : xq;
        id   = c_im_n ? -xi : xi;
        qd   = c_im_n ? -xq : xq;
        d_re = ic + qd;
        d_im = qc - id;
    end
endmodule

// File: rtl/qct_decide.sv
// Energy comparison of the early and late sums against a threshold.
module qct_decide import qct_pkg::*; #(
    parameter int ACC_W = 16,
    parameter int THR_W = 32
) (
    input  logic signed [ACC_W-1:0] e_re,
    input  logic signed [ACC_W-1:0] e_im,
    input  logic signed [ACC_W-1:0] l_re,
    input  logic signed [ACC_W-1:0] l_im,
    input  logic        [THR_W-1:0] thr,
    output trk_flag_e               verdict
);
    localparam int PWR_W = 2 * ACC_W + 1;
    localparam int CMP_W = ((PWR_W > THR_W) ? PWR_W : THR_W) + 1;

    logic signed [PWR_W-1:0] xer, xei, xlr, xli, pe_s, pl_s;
    logic        [CMP_W-1:0] pe_c, pl_c, th_c;

    always_comb begin
        xer  = PWR_W'(e_re);
        xei  = PWR_W'(e_im);
        xlr  = PWR_W'(l_re);
        xli  = PWR_W'(l_im);
        pe_s = xer * xer + xei * xei;
        pl_s = xlr * xlr + xli * xli;
        pe_c = CMP_W'($unsigned(pe_s));
        pl_c = CMP_W'($unsigned(pl_s));
        th_c = CMP_W'(thr);
        if (pe_c > pl_c + th_c)
            verdict = TRK_EARLY;
        else if (pl_c > pe_c + th_c)
            verdict = TRK_LATE;
        else
            verdict = TRK_ON;
    end
endmodule

// File: rtl/qct_tracker.sv
// Quarter-chip early/late sampling phase tracker.
module qct_tracker import qct_pkg::*; #(
    parameter int SMP_W    = 8,
    parameter int SF       = 256,
    parameter int CODE_LEN = 38400,
    parameter int THR_W    = 32,
    parameter int ADDR_W   = $clog2(CODE_LEN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_vld,
    input  logic [4*SMP_W-1:0]   smp_i,
    input  logic [4*SMP_W-1:0]   smp_q,
    input  logic                 code_re_n,
    input  logic                 code_im_n,
    input  logic [THR_W-1:0]     thr,
    output logic [ADDR_W-1:0]    code_addr,
    output logic [1:0]           phase_idx,
    output logic [1:0]           flag,
    output logic                 flag_vld,
    output logic                 rake_vld,
    output logic [SMP_W-1:0]     rake_i,
    output logic [SMP_W-1:0]     rake_q
);
    localparam int DSP_W = SMP_W + 2;
    localparam int CNT_W = $clog2(SF);
    localparam int ACC_W = DSP_W + CNT_W;

    typedef struct packed {
        logic [1:0]              idx;
        logic [CNT_W-1:0]        cnt;
        logic signed [ACC_W-1:0] e_re;
        logic signed [ACC_W-1:0] e_im;
        logic signed [ACC_W-1:0] l_re;
        logic signed [ACC_W-1:0] l_im;
        logic [ADDR_W-1:0]       addr;
        logic [1:0]              flag;
        logic                    flag_vld;
        logic                    rake_vld;
        logic [SMP_W-1:0]        rake_i;
        logic [SMP_W-1:0]        rake_q;
    } trk_state_t;

    trk_state_t st_d, st_q;

    // Split the sample vectors into per-phase lanes.
    logic signed [SMP_W-1:0] ph_i [4];
    logic signed [SMP_W-1:0] ph_q [4];
    for (genvar k = 0; k < 4; k++) begin : g_phase
        assign ph_i[k] = smp_i[k*SMP_W +: SMP_W];
        assign ph_q[k] = smp_q[k*SMP_W +: SMP_W];
    end

    logic [1:0] early_sel, late_sel;
    assign early_sel = st_q.idx - 2'd1;
    assign late_sel  = st_q.idx + 2'd1;

    logic signed [DSP_W-1:0] de_re, de_im, dl_re, dl_im;

    qct_despread #(.SMP_W(SMP_W), .DSP_W(DSP_W)) u_dsp_early (
        .s_i(ph_i[early_sel]), .s_q(ph_q[early_sel]),
        .c_re_n(code_re_n), .c_im_n(code_im_n),
        .d_re(de_re), .d_im(de_im)
    );

    qct_despread #(.SMP_W(SMP_W), .DSP_W(DSP_W)) u_dsp_late (
        .s_i(ph_i[late_sel]), .s_q(ph_q[late_sel]),
        .c_re_n(code_re_n), .c_im_n(code_im_n),
        .d_re(dl_re), .d_im(dl_im)
    );

    logic signed [ACC_W-1:0] sum_e_re, sum_e_im, sum_l_re, sum_l_im;
    assign sum_e_re = st_q.e_re + ACC_W'(de_re);
    assign sum_e_im = st_q.e_im + ACC_W'(de_im);
    assign sum_l_re = st_q.l_re + ACC_W'(dl_re);
    assign sum_l_im = st_q.l_im + ACC_W'(dl_im);

    trk_flag_e verdict;

    qct_decide #(.ACC_W(ACC_W), .THR_W(THR_W)) u_decide (
        .e_re(sum_e_re), .e_im(sum_e_im),
        .l_re(sum_l_re), .l_im(sum_l_im),
        .thr(thr), .verdict(verdict)
    );

    logic              last_chip;
    logic [1:0]        addr_inc;
    logic [ADDR_W:0]   addr_sum;

    always_comb begin
        st_d          = st_q;
        st_d.flag_vld = 1'b0;
        st_d.rake_vld = smp_vld;
        last_chip     = smp_vld && (st_q.cnt == CNT_W'(SF - 1));
        addr_inc      = 2'd1;
        addr_sum      = '0;
        if (smp_vld) begin
            st_d.rake_i = ph_i[st_q.idx];
            st_d.rake_q = ph_q[st_q.idx];
            st_d.cnt    = st_q.cnt + CNT_W'(1);
            st_d.e_re   = sum_e_re;
            st_d.e_im   = sum_e_im;
            st_d.l_re   = sum_l_re;
            st_d.l_im   = sum_l_im;
            if (last_chip) begin
                st_d.cnt      = '0;
                st_d.e_re     = '0;
                st_d.e_im     = '0;
                st_d.l_re     = '0;
                st_d.l_im     = '0;
                st_d.flag     = verdict;
                st_d.flag_vld = 1'b1;
                case (verdict)
                    TRK_EARLY: begin
                        st_d.idx = st_q.idx - 2'd1;
                        if (st_q.idx == 2'd0) addr_inc = 2'd0;
                    end
                    TRK_LATE: begin
                        st_d.idx = st_q.idx + 2'd1;
                        if (st_q.idx == 2'd3) addr_inc = 2'd2;
                    end
                    default: ;
                endcase
            end
            addr_sum = {1'b0, st_q.addr} + (ADDR_W+1)'(addr_inc);
            if (addr_sum >= (ADDR_W+1)'(CODE_LEN))
                addr_sum = addr_sum - (ADDR_W+1)'(CODE_LEN);
            st_d.addr = addr_sum[ADDR_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_addr = st_q.addr;
    assign phase_idx = st_q.idx;
    assign flag      = st_q.flag;
    assign flag_vld  = st_q.flag_vld;
    assign rake_vld  = st_q.rake_vld;
    assign rake_i    = st_q.rake_i;
    assign rake_q    = st_q.rake_q;
endmodule

// File: rtl/qct_tracker_chk.sv
module qct_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       smp_vld,
    input logic [1:0] phase_idx,
    input logic [1:0] flag,
    input logic       flag_vld,
    input logic       rake_vld
);
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_flag_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flag != 2'b11);

    assert_idx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !flag_vld) |-> $stable(phase_idx));

    assert_idx_early_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && flag_vld && flag == 2'b01) |-> (phase_idx + 2'd1) == $past(phase_idx));

    assert_idx_late_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && flag_vld && flag == 2'b10) |-> phase_idx == ($past(phase_idx) + 2'd1));

    assert_idx_ontime_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && flag_vld && flag == 2'b00) |-> $stable(phase_idx));

    assert_rake_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (rake_vld == $past(smp_vld)));

    assert_decide_on_chip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && flag_vld) |-> $past(smp_vld));
endmodule

bind qct_tracker qct_tracker_chk u_chk (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .phase_idx(phase_idx),
    .flag(flag), .flag_vld(flag_vld), .rake_vld(rake_vld)
);

// File: tb/qct_tracker_test.sv
`timescale 1ns/1ps
module qct_tracker_test;
    localparam int SW  = 8;
    localparam int SFT = 16;
    localparam int CL  = 40;
    localparam int TW  = 32;
    localparam int AWT = $clog2(CL);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            smp_vld = 1'b0;
    logic [4*SW-1:0] smp_i = '0;
    logic [4*SW-1:0] smp_q = '0;
    logic            code_re_n = 1'b0;
    logic            code_im_n = 1'b0;
    logic [TW-1:0]   thr = '0;
    logic [AWT-1:0]  code_addr;
    logic [1:0]      phase_idx;
    logic [1:0]      flag;
    logic            flag_vld;
    logic            rake_vld;
    logic [SW-1:0]   rake_i;
    logic [SW-1:0]   rake_q;

    always #2.5 clk = ~clk;

    qct_tracker #(.SMP_W(SW), .SF(SFT), .CODE_LEN(CL), .THR_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_i(smp_i), .smp_q(smp_q),
        .code_re_n(code_re_n), .code_im_n(code_im_n), .thr(thr),
        .code_addr(code_addr), .phase_idx(phase_idx), .flag(flag),
        .flag_vld(flag_vld), .rake_vld(rake_vld), .rake_i(rake_i), .rake_q(rake_q)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state
    int     m_idx = 0, m_cnt = 0, m_addr = 0, m_dec = 0;
    longint a_er = 0, a_ei = 0, a_lr = 0, a_li = 0;
    int     e_flag = 0, e_fv = 0, e_rv = 0, e_ri = 0, e_rq = 0;
    int     amp [4];
    int     cur_i [4];
    int     cur_q [4];
    int     cur_c = 1, cur_d = 1;
    int     noise = 0;
    int     vld_pct = 100;

    function automatic int code_c(int a);
        return (((a * 13 + 5) % 7) > 3) ? -1 : 1;
    endfunction
    function automatic int code_d(int a);
        return (((a * 5 + 1) % 3) == 0) ? -1 : 1;
    endfunction

    task automatic check(string tag, string what, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R2", "rake_vld", int'(rake_vld), e_rv);
        if (e_rv != 0) begin
            check("R2", "rake_i", int'($signed(rake_i)), e_ri);
            check("R2", "rake_q", int'($signed(rake_q)), e_rq);
        end
        check("R4", "flag_vld", int'(flag_vld), e_fv);
        check("R3,R5", "flag", int'(flag), e_flag);
        check("R6", "phase_idx", int'(phase_idx), m_idx);
        check("R7", "code_addr", int'(code_addr), m_addr);
    endtask

    task automatic drive(bit v);
        cur_c = code_c(m_addr);
        cur_d = code_d(m_addr);
        smp_vld   = v;
        code_re_n = (cur_c < 0);
        code_im_n = (cur_d < 0);
        for (int k = 0; k < 4; k++) begin
            int ni, nq;
            ni = (noise > 0) ? ($urandom_range(0, 2 * noise) - noise) : 0;
            nq = (noise > 0) ? ($urandom_range(0, 2 * noise) - noise) : 0;
            cur_i[k] = amp[k] * cur_c + ni;
            cur_q[k] = amp[k] * cur_d + nq;
            smp_i[k*SW +: SW] = cur_i[k][SW-1:0];
            smp_q[k*SW +: SW] = cur_q[k][SW-1:0];
        end
    endtask

    task automatic model_step();
        e_fv = 0;
        if (!smp_vld) begin
            e_rv = 0;
            return;
        end
        begin
            int ek, lk, inc, old;
            longint pe, pl, th;
            e_rv = 1;
            e_ri = cur_i[m_idx];
            e_rq = cur_q[m_idx];
            ek = (m_idx + 3) % 4;
            lk = (m_idx + 1) % 4;
            a_er += cur_i[ek] * cur_c + cur_q[ek] * cur_d;
            a_ei += cur_q[ek] * cur_c - cur_i[ek] * cur_d;
            a_lr += cur_i[lk] * cur_c + cur_q[lk] * cur_d;
            a_li += cur_q[lk] * cur_c - cur_i[lk] * cur_d;
            m_cnt++;
            inc = 1;
            if (m_cnt == SFT) begin
                pe = a_er * a_er + a_ei * a_ei;
                pl = a_lr * a_lr + a_li * a_li;
                th = longint'(thr);
                old = m_idx;
                if (pe > pl + th) begin
                    e_flag = 1;
                    m_idx = (old + 3) % 4;
                    if (old == 0) inc = 0;
                end else if (pl > pe + th) begin
                    e_flag = 2;
                    m_idx = (old + 1) % 4;
                    if (old == 3) inc = 2;
                end else begin
                    e_flag = 0;
                end
                a_er = 0; a_ei = 0; a_lr = 0; a_li = 0;
                m_cnt = 0;
                e_fv = 1;
                m_dec++;
            end
            m_addr = (m_addr + inc) % CL;
        end
    endtask

    task automatic tick(bit v);
        compare_all();
        drive(v);
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic run_decisions(int n);
        int target;
        target = m_dec + n;
        while (m_dec < target) begin
            tick($urandom_range(0, 99) < vld_pct);
        end
    endtask

    task automatic set_peak(int p);
        for (int k = 0; k < 4; k++) amp[k] = 0;
        amp[p]           = 40;
        amp[(p + 1) % 4] = 20;
        amp[(p + 3) % 4] = 20;
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin amp[k] = 0; cur_i[k] = 0; cur_q[k] = 0; end
        repeat (4) @(negedge clk);
        // R1: state while reset is held
        check("R1", "phase_idx", int'(phase_idx), 0);
        check("R1", "flag", int'(flag), 0);
        check("R1", "flag_vld", int'(flag_vld), 0);
        check("R1", "rake_vld", int'(rake_vld), 0);
        check("R1", "code_addr", int'(code_addr), 0);
        rst_n = 1'b1;

        thr = 32'd100;
        // Peak moves late one phase at a time, wrapping 3 -> 0 (R6, R7)
        set_peak(1); run_decisions(1);
        check("R6", "idx after late step", int'(phase_idx), 1);
        run_decisions(1);
        check("R6", "idx held on-time", int'(phase_idx), 1);
        set_peak(2); run_decisions(2);
        set_peak(3); run_decisions(2);
        check("R6", "idx at 3", int'(phase_idx), 3);
        set_peak(0); run_decisions(1);
        check("R6", "idx wrapped to 0", int'(phase_idx), 0);
        check("R7", "flag late on wrap", int'(flag), 2);
        run_decisions(1);
        // Peak moves early across 0 -> 3
        set_peak(3); run_decisions(1);
        check("R6", "idx wrapped to 3", int'(phase_idx), 3);
        check("R5", "flag early on wrap", int'(flag), 1);
        run_decisions(1);

        // R8: energy difference exactly at threshold (early tap only: Pe=(2*1*16)^2=1024)
        for (int k = 0; k < 4; k++) amp[k] = 0;
        amp[2] = 1;
        thr = 32'd1024;
        run_decisions(1);
        check("R8", "flag at equal threshold", int'(flag), 0);
        check("R8", "idx at equal threshold", int'(phase_idx), 3);
        thr = 32'd1023;
        run_decisions(1);
        check("R8", "flag one below threshold", int'(flag), 1);
        check("R8", "idx one below threshold", int'(phase_idx), 2);

        // R5: huge threshold suppresses all moves
        thr = 32'hFFFF_FFFF;
        set_peak(0); run_decisions(2);
        check("R5", "idx with huge threshold", int'(phase_idx), 2);

        // R4: gaps in sample valid, noisy random peaks
        vld_pct = 65;
        noise   = 6;
        for (int r = 0; r < 30; r++) begin
            thr = TW'($urandom_range(0, 40000));
            set_peak($urandom_range(0, 3));
            run_decisions(1);
        end
        tick(1'b0);
        tick(1'b0);
        compare_all();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule